// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block owns the descriptor table of a 10/100 Ethernet MAC and moves frames between software and the MAC. A host fills descriptors through a 32-bit register bus. The engine walks a transmit ring, hands ready frames to a simplified transmit port, and writes completion status back. It fills empty receive descriptors with the length and error status reported by a simplified receive port. It also sets maskable interrupt-source bits. Data movement, the MAC datapath and the PHY are outside this block.

Transmit and receive descriptors live in one table that is split at a programmable transmit count. Ownership passes between host and engine through a per-descriptor ownership bit. Each ring wraps on a per-descriptor wrap flag, with a hard stop at the ring's end.

Each descriptor holds two words. Word 0 is control and status: bit 15 is the ownership bit, bit 14 requests an interrupt, bit 13 is the wrap flag, and bits 31:16 hold the length. Word 1 is the buffer address.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset the mode register (0x000), interrupt-source register (0x004) and mask register (0x008) read 0, the transmit-count register (0x020) reads 64, and `tx_req` and `irq` are low.
- R2: Word 0 of descriptor n is at byte address 0x400+8n and word 1 is at 0x404+8n, for n from 0 to 127. A host write to either word reads back unchanged.
- R3: A write to the transmit-count register stores the value, clamped to 128. It moves the transmit ring to descriptor 0 and the receive ring to descriptor index equal to the new count.
- R4: When mode bit 1 is set and word 0 of the current transmit descriptor has bit 15 set, the engine raises `tx_req`. The port then shows word 1 as `tx_addr`, word-0 bits 31:16 as `tx_len`, bit 12 as `tx_pad` and bit 11 as `tx_crc`. With mode bit 1 clear, no frame starts.
- R5: On `tx_done`, the engine writes word 0 back with bits 8:0 set to `tx_stat`, bit 15 cleared, and bits 31:16 and 14:9 unchanged.
- R6: After a transmit descriptor is completed, the ring moves to descriptor 0 if that descriptor's bit 13 was set or it was the last transmit descriptor (count-1). Otherwise it moves to the next descriptor.
- R7: On `rx_done` with mode bit 0 set, if the current receive descriptor has bit 15 set, the engine writes word 0 as: `rx_len` in bits 31:16, bit 15 cleared, bits 14:9 unchanged, and `rx_stat` in bits 8:0.
- R8: After a receive descriptor is filled, the ring moves to the descriptor index equal to the transmit count if bit 13 was set or the index was 127. Otherwise it moves to the next descriptor.
- R9: A frame that arrives while the current receive descriptor is not empty, or while the transmit count is 128, sets source bit 4. The descriptor and the ring position stay unchanged. A frame that arrives while mode bit 0 is clear is ignored entirely.
- R10: When the completed descriptor has bit 14 set, the engine sets a source bit as follows:
  - Transmit: bit 1 if any of `tx_stat` bits 0, 2, 3 or 8 is set, otherwise bit 0.
  - Receive: bit 3 if any of `rx_stat` bits 7:0 is set, otherwise bit 2. Bit 6 is also set when `rx_stat` bit 8 is set.
  - When bit 14 is clear, no source bit is set.
- R11: A source bit is set only while the matching mask bit is 1. `irq` is high whenever any source bit is set.
- R12: Writing the source register clears each bit written as 1 and keeps each bit written as 0.
- R13: In any cycle with a host bus write, the engine neither starts a frame nor writes a descriptor; it defers until the bus is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register bus |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: any source bit set |
| tx_req | output | 1 | A transmit frame is in progress |
| tx_addr | output | 32 | Buffer address of the current frame |
| tx_len | output | 16 | Length of the current frame |
| tx_pad | output | 1 | Pad request of the current frame |
| tx_crc | output | 1 | CRC-append request of the current frame |
| tx_done | input | 1 | One-cycle pulse: frame finished |
| tx_stat | input | 9 | Completion status, valid with `tx_done` |
| rx_done | input | 1 | One-cycle pulse: a received frame ended |
| rx_len | input | 16 | Received length including CRC |
| rx_stat | input | 9 | Receive error and control status |

## Verification
The bench goes after several kinds of mistake:
- Status-to-interrupt decode: it sweeps all 512 transmit and all 512 receive status codes. A wrong error mask would raise the done bit where the error bit belongs, or would corrupt status bits in the written-back word.
- Ring turns: it covers the wrap flag, the implicit end of the transmit ring, and the implicit end of the table on the receive side. A design that got these wrong would serve a descriptor past the wrap, or run into the other ring.
- Full receive ring: a design that got this wrong would overwrite a filled descriptor or skip past it instead of reporting busy.
- Bus priority: a frame must stay unstarted while the host keeps writing.
- Masking: a source bit must not be set while its mask bit is clear.
- Clearing: the source register must keep each bit written as 0.

// File: rtl/bd_pkg.sv
// Shared constants for the descriptor ring engine: control-word bit
// positions, interrupt-source positions, register offsets and states.
package bd_pkg;
    localparam int unsigned OWN_B  = 15;  // ready (tx) / empty (rx)
    localparam int unsigned IREQ_B = 14;
    localparam int unsigned WRAP_B = 13;
    localparam int unsigned PAD_B  = 12;
    localparam int unsigned CRC_B  = 11;

    localparam int unsigned IRQW       = 7;
    localparam int unsigned IS_TX_OK   = 0;
    localparam int unsigned IS_TX_ERR  = 1;
    localparam int unsigned IS_RX_OK   = 2;
    localparam int unsigned IS_RX_ERR  = 3;
    localparam int unsigned IS_BUSY    = 4;
    localparam int unsigned IS_RX_CTRL = 6;

    localparam logic [8:0] TX_ERR_BITS = 9'h10D;  // carrier, late coll, retry limit, underrun
    localparam logic [8:0] RX_ERR_BITS = 9'h0FF;

    localparam logic [11:0] OFF_MODE  = 12'h000;
    localparam logic [11:0] OFF_ISRC  = 12'h004;
    localparam logic [11:0] OFF_IMASK = 12'h008;
    localparam logic [11:0] OFF_TXCNT = 12'h020;

    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WB} tx_state_e;
endpackage

// File: rtl/bd_regs.sv
// Control registers: ring enables, interrupt mask, write-one-to-clear
// interrupt sources and the clamped transmit descriptor count.
// Assumes one bus write per cycle and decodes full byte addresses.
module bd_regs
    import bd_pkg::*;
#(
    parameter int unsigned NUM_BD = 128,
    localparam int unsigned CW    = $clog2(NUM_BD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     bus_addr,
    input  logic            bus_we,
    input  logic [31:0]     bus_wdata,
    input  logic [IRQW-1:0] ev_set,
    output logic            tx_en,
    output logic            rx_en,
    output logic [CW-1:0]   tx_count,
    output logic            count_wr,
    output logic [CW-1:0]   count_next,
    output logic [31:0]     reg_rdata,
    output logic            irq
);
    localparam logic [CW-1:0] RST_COUNT = CW'(NUM_BD / 2);

    logic [1:0]      mode_q;
    logic [IRQW-1:0] mask_q;
    logic [IRQW-1:0] src_q;
    logic [IRQW-1:0] clr;

    // Decode writes and clamp the requested transmit count.
    always_comb begin
        count_wr   = bus_we && (bus_addr == OFF_TXCNT);
        count_next = (bus_wdata > 32'(NUM_BD)) ? CW'(NUM_BD) : bus_wdata[CW-1:0];
        clr        = (bus_we && (bus_addr == OFF_ISRC)) ? bus_wdata[IRQW-1:0] : '0;
    end

    // Register updates; a masked event sets its source bit even if cleared this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            mask_q   <= '0;
            src_q    <= '0;
            tx_count <= RST_COUNT;
        end else begin
            if (bus_we && bus_addr == OFF_MODE)  mode_q <= bus_wdata[1:0];
            if (bus_we && bus_addr == OFF_IMASK) mask_q <= bus_wdata[IRQW-1:0];
            if (count_wr)                        tx_count <= count_next;
            src_q <= (src_q & ~clr) | (ev_set & mask_q);
        end
    end

    // Read mux for the register space.
    always_comb begin
        case (bus_addr)
            OFF_MODE:  reg_rdata = {30'b0, mode_q};
            OFF_ISRC:  reg_rdata = {{(32-IRQW){1'b0}}, src_q};
            OFF_IMASK: reg_rdata = {{(32-IRQW){1'b0}}, mask_q};
            OFF_TXCNT: reg_rdata = 32'(tx_count);
            default:   reg_rdata = '0;
        endcase
    end

    assign rx_en = mode_q[0];
    assign tx_en = mode_q[1];
    assign irq   = |src_q;

    // R11: a newly set source bit had its mask bit set
    p_src_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~$past(src_q) & ~$past(mask_q)) == '0);
    // R3: count never exceeds the table size
    p_count_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(NUM_BD));
endmodule

// File: rtl/bd_tx_walker.sv
// Transmit ring walker: polls the current descriptor for the ready bit,
// drives the frame port until done, then writes status back and advances.
// Assumes tx_done only arrives while tx_req is high.
module bd_tx_walker
    import bd_pkg::*;
#(
    parameter int unsigned NUM_BD = 128,
    localparam int unsigned CW    = $clog2(NUM_BD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [CW-1:0] tx_count,
    input  logic          count_wr,
    input  logic          host_busy,
    input  logic [31:9]   cur_w0,
    input  logic [31:0]   cur_w1,
    input  logic          grant,
    input  logic          tx_done,
    input  logic [8:0]    tx_stat,
    output logic [CW-1:0] ptr,
    output logic          wr_req,
    output logic [31:0]   wr_data,
    output logic          tx_req,
    output logic [31:0]   tx_addr,
    output logic [15:0]   tx_len,
    output logic          tx_pad,
    output logic          tx_crc,
    output logic          ev_ok,
    output logic          ev_err
);
    tx_state_e   state;
    logic [31:9] w0_q;
    logic [8:0]  stat_q;
    logic        last;
    logic        is_err;

    // Ring turn and error classification of the frame in hand.
    always_comb begin
        last   = w0_q[WRAP_B] || (ptr == tx_count - CW'(1));
        is_err = |(stat_q & TX_ERR_BITS);
    end

    // Descriptor state machine and ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            ptr     <= '0;
            w0_q    <= '0;
            tx_addr <= '0;
            stat_q  <= '0;
        end else begin
            case (state)
                TX_IDLE: if (tx_en && !host_busy && tx_count != '0 && cur_w0[OWN_B]) begin
                    w0_q    <= cur_w0;
                    tx_addr <= cur_w1;
                    state   <= TX_SEND;
                end
                TX_SEND: if (tx_done) begin
                    stat_q <= tx_stat;
                    state  <= TX_WB;
                end
                TX_WB: if (grant) begin
                    ptr   <= last ? '0 : ptr + CW'(1);
                    state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
            if (count_wr) ptr <= '0;
        end
    end

    // Frame port, write-back word and interrupt events.
    always_comb begin
        tx_req  = (state == TX_SEND);
        tx_len  = w0_q[31:16];
        tx_pad  = w0_q[PAD_B];
        tx_crc  = w0_q[CRC_B];
        wr_req  = (state == TX_WB);
        wr_data = {w0_q[31:16], 1'b0, w0_q[14:9], stat_q};
        ev_ok   = grant && w0_q[IREQ_B] && !is_err;
        ev_err  = grant && w0_q[IREQ_B] && is_err;
    end

    // R4, R13: a frame starts only when enabled and the bus was quiet
    p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(tx_en) && !$past(host_busy));
    // R5: the request holds until the frame completes
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !tx_done |=> tx_req);
    // R6: the pointer stays inside the transmit ring
    p_ptr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count != '0 |-> ptr < tx_count);
endmodule

// File: rtl/bd_rx_filler.sv
// Receive ring filler: latches a finished frame's length and status,
// then fills the current empty descriptor or reports busy.
// Assumes rx_done pulses are spaced at least three cycles apart.
module bd_rx_filler
    import bd_pkg::*;
#(
    parameter int unsigned NUM_BD = 128,
    localparam int unsigned CW    = $clog2(NUM_BD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [CW-1:0] tx_count,
    input  logic          count_wr,
    input  logic [CW-1:0] count_next,
    input  logic          host_busy,
    input  logic [15:9]   cur_ctl,
    input  logic          rx_done,
    input  logic [15:0]   rx_len,
    input  logic [8:0]    rx_stat,
    output logic [CW-1:0] ptr,
    output logic          wr_req,
    output logic [31:0]   wr_data,
    output logic          ev_ok,
    output logic          ev_err,
    output logic          ev_ctrl,
    output logic          ev_busy
);
    localparam logic [CW-1:0] RST_PTR = CW'(NUM_BD / 2);

    logic        pend_q;
    logic [15:0] len_q;
    logic [8:0]  stat_q;
    logic        act;
    logic        has_ring;
    logic        fill;
    logic        err;

    // Decide between filling the descriptor and reporting busy.
    always_comb begin
        has_ring = tx_count < CW'(NUM_BD);
        act      = pend_q && !host_busy;
        fill     = act && has_ring && cur_ctl[OWN_B];
        err      = |(stat_q & RX_ERR_BITS);
        wr_req   = fill;
        wr_data  = {len_q, 1'b0, cur_ctl[14:9], stat_q};
        ev_ok    = fill && cur_ctl[IREQ_B] && !err;
        ev_err   = fill && cur_ctl[IREQ_B] && err;
        ev_ctrl  = fill && cur_ctl[IREQ_B] && stat_q[8];
        ev_busy  = act && !(has_ring && cur_ctl[OWN_B]);
    end

    // Pending frame capture and ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            len_q  <= '0;
            stat_q <= '0;
            ptr    <= RST_PTR;
        end else begin
            if (act) pend_q <= 1'b0;
            if (rx_done && rx_en) begin
                pend_q <= 1'b1;
                len_q  <= rx_len;
                stat_q <= rx_stat;
            end
            if (fill)
                ptr <= (cur_ctl[WRAP_B] || ptr == CW'(NUM_BD - 1)) ? tx_count : ptr + CW'(1);
            if (count_wr) ptr <= count_next;
        end
    end

    // R8: the pointer stays in the receive part of the table
    p_ptr_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr >= tx_count && ptr <= CW'(NUM_BD));
    // R9: a busy drop leaves the ring position alone
    p_busy_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy && !count_wr |=> $stable(ptr));
endmodule

// File: rtl/bd_ring_engine.sv
// Top of the descriptor ring engine: descriptor table, bus decode and
// the single write port shared by host, receive filler and transmit walker.
// Host writes win; the receive side goes before the transmit side.
module bd_ring_engine
    import bd_pkg::*;
#(
    parameter int unsigned NUM_BD = 128,
    localparam int unsigned CW    = $clog2(NUM_BD + 1),
    localparam int unsigned MW    = 2 * NUM_BD,
    localparam int unsigned MIW   = $clog2(MW)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        tx_req,
    output logic [31:0] tx_addr,
    output logic [15:0] tx_len,
    output logic        tx_pad,
    output logic        tx_crc,
    input  logic        tx_done,
    input  logic [8:0]  tx_stat,
    input  logic        rx_done,
    input  logic [15:0] rx_len,
    input  logic [8:0]  rx_stat
);
    logic [31:0]     mem [MW];
    logic            desc_sel, host_desc_we;
    logic [MIW-1:0]  host_idx, tx_idx, rx_idx;
    logic [31:0]     reg_rdata;
    logic            tx_en, rx_en, count_wr;
    logic [CW-1:0]   tx_count, count_next, tx_ptr, rx_ptr;
    logic            tx_wr_req, rx_wr_req, tx_grant, rx_grant;
    logic [31:0]     tx_wr_data, rx_wr_data;
    logic            ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_rx_ctrl, ev_busy;
    logic [IRQW-1:0] ev_set;

    // Address decode, word-0 indices of the two ring heads, and arbitration.
    always_comb begin
        desc_sel     = (bus_addr[11:10] == 2'b01);
        host_desc_we = bus_we && desc_sel;
        host_idx     = bus_addr[MIW+1:2];
        tx_idx       = {tx_ptr[MIW-2:0], 1'b0};
        rx_idx       = {rx_ptr[MIW-2:0], 1'b0};
        rx_grant     = rx_wr_req && !bus_we;
        tx_grant     = tx_wr_req && !bus_we && !rx_wr_req;
        bus_rdata    = desc_sel ? mem[host_idx] : reg_rdata;
        ev_set       = '0;
        ev_set[IS_TX_OK]   = ev_tx_ok;
        ev_set[IS_TX_ERR]  = ev_tx_err;
        ev_set[IS_RX_OK]   = ev_rx_ok;
        ev_set[IS_RX_ERR]  = ev_rx_err;
        ev_set[IS_BUSY]    = ev_busy;
        ev_set[IS_RX_CTRL] = ev_rx_ctrl;
    end

    // Single descriptor write port.
    always_ff @(posedge clk) begin
        if (host_desc_we)  mem[host_idx] <= bus_wdata;
        else if (rx_grant) mem[rx_idx]   <= rx_wr_data;
        else if (tx_grant) mem[tx_idx]   <= tx_wr_data;
    end

    bd_regs #(.NUM_BD(NUM_BD)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .ev_set(ev_set), .tx_en(tx_en), .rx_en(rx_en),
        .tx_count(tx_count), .count_wr(count_wr), .count_next(count_next),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    bd_tx_walker #(.NUM_BD(NUM_BD)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_count(tx_count),
        .count_wr(count_wr), .host_busy(bus_we), .cur_w0(mem[tx_idx][31:9]),
        .cur_w1(mem[tx_idx + MIW'(1)]), .grant(tx_grant), .tx_done(tx_done),
        .tx_stat(tx_stat), .ptr(tx_ptr), .wr_req(tx_wr_req), .wr_data(tx_wr_data),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .ev_ok(ev_tx_ok), .ev_err(ev_tx_err)
    );

    bd_rx_filler #(.NUM_BD(NUM_BD)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_count(tx_count),
        .count_wr(count_wr), .count_next(count_next), .host_busy(bus_we),
        .cur_ctl(mem[rx_idx][15:9]), .rx_done(rx_done), .rx_len(rx_len),
        .rx_stat(rx_stat), .ptr(rx_ptr), .wr_req(rx_wr_req), .wr_data(rx_wr_data),
        .ev_ok(ev_rx_ok), .ev_err(ev_rx_err), .ev_ctrl(ev_rx_ctrl), .ev_busy(ev_busy)
    );

    // R13: at most one agent writes the table in a cycle
    p_one_writer_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_desc_we, rx_grant, tx_grant}));
    // R5: a transmit write-back never coincides with a host bus write
    p_tx_wb_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> !bus_we);
endmodule

// File: tb/bd_ring_engine_tb.sv
`timescale 1ns/1ps
module bd_ring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_req, tx_pad, tx_crc;
    logic [31:0] tx_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_stat = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bd_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
        .rx_done(rx_done), .rx_len(rx_len), .rx_stat(rx_stat)
    );

    function automatic logic [11:0] w0a(input int n);
        return 12'(12'h400 + 8 * n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_req(input string tag);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_req) break;
        end
        chk(tag, 32'(tx_req), 32'd1);
    endtask

    task automatic tx_finish(input logic [8:0] s);
        @(negedge clk); tx_done = 1'b1; tx_stat = s;
        @(negedge clk); tx_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [15:0] l, input logic [8:0] s);
        @(negedge clk); rx_done = 1'b1; rx_len = l; rx_stat = s;
        @(negedge clk); rx_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] exp;
        logic [15:0] l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 mode", 12'h000, 32'h0);
        rd_chk("R1 source", 12'h004, 32'h0);
        rd_chk("R1 mask", 12'h008, 32'h0);
        rd_chk("R1 txcount", 12'h020, 32'd64);
        chk("R1 tx_req/irq", {30'b0, tx_req, irq}, 32'h0);

        // R2 descriptor map
        wr(w0a(5), 32'hA5A5_0123);
        rd_chk("R2 word0 n=5", w0a(5), 32'hA5A5_0123);
        wr(w0a(127) + 12'h4, 32'hDEAD_BEEF);
        rd_chk("R2 word1 n=127", 12'h7FC, 32'hDEAD_BEEF);

        // R3 clamp
        wr(12'h020, 32'd200);
        rd_chk("R3 clamp 200", 12'h020, 32'd128);
        wr(12'h020, 32'd129);
        rd_chk("R3 clamp 129", 12'h020, 32'd128);
        wr(12'h020, 32'd4);
        rd_chk("R3 store 4", 12'h020, 32'd4);
        wr(12'h008, 32'h7F);

        // R4 disabled: ready descriptor does not start
        wr(w0a(0) + 12'h4, 32'h1000);
        wr(w0a(0), {16'd100, 16'hE000});
        repeat (5) @(negedge clk);
        chk("R4 disabled no start", 32'(tx_req), 32'd0);

        // R13: enable while keeping the bus busy
        @(negedge clk); bus_addr = 12'h000; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk); bus_addr = 12'h008; bus_wdata = 32'h7F;
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (tx_req) seen = 1'b1;
            end
            chk("R13 no start during host writes", 32'(seen), 32'd0);
        end
        bus_we = 1'b0;
        wait_req("R13 start after bus quiet");
        tx_finish(9'h0);
        rd_chk("R10 tx ok source", 12'h004, 32'h1);
        // R12 write-one-to-clear
        wr(12'h004, 32'h0);
        rd_chk("R12 zero keeps", 12'h004, 32'h1);
        wr(12'h004, 32'h1);
        rd_chk("R12 one clears", 12'h004, 32'h0);

        // R4/R5/R10 transmit status sweep over descriptor 0 (wrap set)
        for (int s = 0; s < 512; s++) begin
            logic [8:0] st = 9'(s);
            l = 16'(60 + s);
            wr(w0a(0) + 12'h4, 32'h2000_0000 + 32'(s));
            wr(w0a(0), {l, 3'b111, st[0], st[1], 11'b0});
            wait_req("R4 start");
            chk("R4 port fields", {tx_addr[15:0], tx_len[13:0], tx_pad, tx_crc},
                {16'(s), l[13:0], st[0], st[1]});
            tx_finish(st);
            rd_chk("R5 writeback", w0a(0), {l, 3'b011, st[0], st[1], 2'b00, st});
            exp = (|(st & 9'h10D)) ? 32'h2 : 32'h1;
            rd_chk("R10 tx source", 12'h004, exp);
            wr(12'h004, 32'h7F);
        end

        // R6 ring order with end-of-ring turn
        wr(12'h020, 32'd3);
        for (int n = 0; n < 3; n++) wr(w0a(n) + 12'h4, 32'h3000 + 32'(n));
        for (int n = 0; n < 3; n++) wr(w0a(n), {16'd64, 16'h8000});
        for (int k = 0; k < 4; k++) begin
            if (k == 3) wr(w0a(0), {16'd64, 16'h8000});
            wait_req("R6 start");
            chk("R6 order end turn", tx_addr, 32'h3000 + 32'(k % 3));
            tx_finish(9'h0);
        end
        // R6 wrap flag on descriptor 1
        wr(w0a(2), {16'd64, 16'h8000});
        wr(w0a(0), {16'd64, 16'h8000});
        wr(w0a(1), {16'd64, 16'hA000});
        wait_req("R6 start");
        chk("R6 serve 1", tx_addr, 32'h3001);
        tx_finish(9'h0);
        wait_req("R6 start");
        chk("R6 wrap to 0", tx_addr, 32'h3000);
        tx_finish(9'h0);
        rd_chk("R10 no irq request no source", 12'h004, 32'h0);

        // R11 mask
        wr(12'h020, 32'd4);
        wr(12'h008, 32'h0);
        wr(w0a(0), {16'd64, 16'hE000});
        wait_req("R11 start");
        tx_finish(9'h0);
        rd_chk("R11 masked source", 12'h004, 32'h0);
        chk("R11 masked irq", 32'(irq), 32'd0);
        wr(12'h008, 32'h1);
        wr(w0a(0), {16'd64, 16'hE000});
        wait_req("R11 start");
        tx_finish(9'h0);
        chk("R11 irq high", 32'(irq), 32'd1);
        wr(12'h004, 32'h7F);
        wr(12'h008, 32'h7F);

        // R9 receive disabled: ignored
        wr(12'h000, 32'h0);
        wr(12'h020, 32'd4);
        wr(w0a(4), 32'h0000_E000);
        rx_frame(16'd100, 9'h0);
        rd_chk("R9 disabled descriptor", w0a(4), 32'h0000_E000);
        rd_chk("R9 disabled source", 12'h004, 32'h0);

        // R7/R10 receive status sweep on descriptor 4 (wrap set)
        wr(12'h000, 32'h1);
        for (int s = 0; s < 512; s++) begin
            logic [8:0] st = 9'(s);
            l = 16'(64 + s);
            wr(w0a(4), 32'h0000_E000);
            rx_frame(l, st);
            rd_chk("R7 fill", w0a(4), {l, 7'b0110000, st});
            exp = ((st[7:0] != 0) ? 32'h8 : 32'h4) | (st[8] ? 32'h40 : 32'h0);
            rd_chk("R10 rx source", 12'h004, exp);
            wr(12'h004, 32'h7F);
        end

        // R8 wrap flag on descriptor 5
        wr(w0a(4), 32'h8000);
        wr(w0a(5), 32'hA000);
        rx_frame(16'd70, 9'h0);
        rx_frame(16'd71, 9'h0);
        wr(w0a(4), 32'h8000);
        rx_frame(16'd72, 9'h0);
        rd_chk("R8 wrap back to 4", w0a(4), {16'd72, 16'h0000});
        rd_chk("R8 desc 5", w0a(5), {16'd71, 16'h2000});

        // R8 turn after the last table index
        wr(12'h020, 32'd125);
        for (int n = 125; n < 128; n++) wr(w0a(n), 32'h8000);
        rx_frame(16'd80, 9'h0);
        rx_frame(16'd81, 9'h0);
        rx_frame(16'd82, 9'h0);
        wr(w0a(125), 32'h8000);
        rx_frame(16'd83, 9'h0);
        rd_chk("R8 end turn to 125", w0a(125), {16'd83, 16'h0000});
        rd_chk("R8 desc 126", w0a(126), {16'd81, 16'h0000});
        rd_chk("R8 desc 127", w0a(127), {16'd82, 16'h0000});

        // R9 busy on a filled descriptor (pointer now 126)
        rx_frame(16'd90, 9'h0);
        rd_chk("R9 filled untouched", w0a(126), {16'd81, 16'h0000});
        rd_chk("R9 busy source", 12'h004, 32'h10);
        wr(12'h004, 32'h7F);
        wr(w0a(126), 32'h8000);
        rx_frame(16'd91, 9'h0);
        rd_chk("R9 pointer kept", w0a(126), {16'd91, 16'h0000});

        // R9 no receive descriptors at all
        wr(12'h020, 32'd128);
        rx_frame(16'd92, 9'h0);
        rd_chk("R9 no ring busy", 12'h004, 32'h10);

        finish_run();
    end
endmodule